// File: doc/BRIEF.md
# Multi-Input Conversion Scan Sequencer

This block sits between a host-side scan controller and a single successive-approximation converter. A one-cycle start pulse launches a scan in one of five modes. Each mode has its own fixed order of input channels. The sequencer asks the converter for one channel at a time, holds the request until the converter answers with a done pulse, and then hands the result on to a result buffer. Along with the result it sends a one-bit identifier, so the host can tell the two halves of a paired sample apart once they sit in the buffer.

The mode and the auxiliary enables are captured when the start pulse is accepted, so the inputs may change during a scan. In the auxiliary mode, channels that are not enabled are skipped. If no auxiliary channel is enabled, the scan ends at once without asking for any conversion. A start pulse that arrives while a scan is running is ignored, and so is a done pulse that arrives while no request is open.

Top module: `scan_sequencer`

## Requirements
- R1: Mode codes on `modeSel` are 0 = pen pair, 1 = pen plus pressure, 2 = pressure pair, 3 = auxiliary scan, 4 = port scan. Channel codes on `chanSel` are X=0, Y=1, Z1=2, Z2=3, BAT=4, AUX1=5, AUX2=6, TEMP=7. Mode 0 requests Y and then X.
- R2: Mode 1 requests Y, X, Z1 and Z2, in that order.
- R3: Mode 2 requests Z1 and then Z2.
- R4: Mode 3 requests AUX1, AUX2 and TEMP, in that order. It skips any channel whose enable is 0. `auxEn` bit 0 enables AUX1, bit 1 enables AUX2 and bit 2 enables TEMP.
- R5: Mode 4 requests BAT, AUX1 and AUX2, in that order.
- R6: `resId` is 0 for results from X, Z1, BAT and AUX2, and 1 for results from Y, Z2, AUX1 and TEMP.
- R7: When `convDone` is sampled high while `convReq` is high, `resValid` is high for exactly the next cycle, with `resData` equal to the sampled `convData`.
- R8: `startPulse` is ignored while `busy` is high. Mode and enables are taken only from the cycle in which the start pulse is accepted.
- R9: A `convDone` sampled while `convReq` is low produces no result.
- R10: Mode 3 with `auxEn` = 0 asserts no request and returns to idle (`busy` low).
- R11: After reset, `busy`, `convReq` and `resValid` are all low.
- R12: `convReq` stays high and `chanSel` stays stable until `convDone` is sampled. After the last channel of the mode, `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 3 | Scan mode code |
| auxEn | input | 3 | Enables for AUX1, AUX2 and TEMP in the auxiliary mode |
| startPulse | input | 1 | Starts a scan when the sequencer is idle |
| convDone | input | 1 | Converter finished the requested conversion |
| convData | input | DATA_W | Converter result |
| chanSel | output | 3 | Channel being requested |
| convReq | output | 1 | Conversion request, level held until done |
| busy | output | 1 | Scan in progress |
| resValid | output | 1 | One-cycle strobe for a buffer write |
| resId | output | 1 | Identifier bit for the result |
| resData | output | DATA_W | Result word for the buffer |

## Verification
The bench aims at the auxiliary-mode skip logic: every enable pattern is covered, including all-zero and gapped patterns such as AUX1 plus TEMP. A sequencer that failed to skip would request a disabled channel, and one that handled the empty case wrongly would hang or issue a stray request. It fires extra start pulses in the middle of scans and changes the mode inputs after a start is accepted. A design that restarted or read the live mode would repeat channels or switch to a different order. It also sends done pulses between requests, which a careless design would turn into phantom buffer writes, and it checks every identifier bit against its channel.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  localparam int CHAN_W = 3;
  localparam int MODE_W = 3;
  localparam int MAX_STEPS = 4;
  localparam int STEP_W = $clog2(MAX_STEPS + 1);

  typedef enum logic [CHAN_W-1:0] {
    CH_X = 3'd0, CH_Y = 3'd1, CH_Z1 = 3'd2, CH_Z2 = 3'd3,
    CH_BAT = 3'd4, CH_AUX1 = 3'd5, CH_AUX2 = 3'd6, CH_TEMP = 3'd7
  } chan_e;

  localparam logic [MODE_W-1:0] MODE_PEN   = 3'd0;
  localparam logic [MODE_W-1:0] MODE_PENZ  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_PRESS = 3'd2;
  localparam logic [MODE_W-1:0] MODE_AUX   = 3'd3;
  localparam logic [MODE_W-1:0] MODE_PORT  = 3'd4;

  typedef struct packed {
    logic load;     // capture mode/enables, rewind step
    logic jump;     // move step to the next usable entry
    logic capture;  // latch result and move past current entry
  } seq_ctl_t;

  // channel found at list position idx for a mode
  function automatic chan_e entryChan(logic [MODE_W-1:0] m, int idx);
    chan_e c;
    c = CH_X;
    case (m)
      MODE_PEN:   c = (idx == 0) ? CH_Y : CH_X;
      MODE_PENZ:  case (idx) 0: c = CH_Y; 1: c = CH_X; 2: c = CH_Z1; default: c = CH_Z2; endcase
      MODE_PRESS: c = (idx == 0) ? CH_Z1 : CH_Z2;
      MODE_AUX:   case (idx) 0: c = CH_AUX1; 1: c = CH_AUX2; default: c = CH_TEMP; endcase
      MODE_PORT:  case (idx) 0: c = CH_BAT; 1: c = CH_AUX1; default: c = CH_AUX2; endcase
      default:    c = CH_X;
    endcase
    return c;
  endfunction

  // whether list position idx exists (and is enabled) for a mode
  function automatic logic entryUsed(logic [MODE_W-1:0] m, logic [2:0] en, int idx);
    logic u;
    case (m)
      MODE_PEN, MODE_PRESS: u = (idx < 2);
      MODE_PENZ:            u = (idx < 4);
      MODE_PORT:            u = (idx < 3);
      MODE_AUX:             u = (idx < 3) && en[idx];
      default:              u = 1'b0;
    endcase
    return u;
  endfunction

  function automatic logic chanId(chan_e c);
    return (c == CH_Y) || (c == CH_Z2) || (c == CH_AUX1) || (c == CH_TEMP);
  endfunction
endpackage

// File: rtl/scan_seq_datapath.sv
module scan_seq_datapath
  import scan_seq_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  seq_ctl_t           ctl,
  input  logic [MODE_W-1:0]  modeSel,
  input  logic [2:0]         auxEn,
  input  logic [DATA_W-1:0]  convData,
  output logic               entryFound,
  output logic [CHAN_W-1:0]  chanSel,
  output logic               resValid,
  output logic               resId,
  output logic [DATA_W-1:0]  resData
);
  logic [MODE_W-1:0] modeQ;
  logic [2:0]        enQ;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] nextIdx;
  logic [MAX_STEPS-1:0] usable;

  genvar gi;
  generate
    for (gi = 0; gi < MAX_STEPS; gi++) begin : g_use
      assign usable[gi] = (STEP_W'(gi) >= step) && entryUsed(modeQ, enQ, gi);
    end
  endgenerate

  always_comb begin
    entryFound = 1'b0;
    nextIdx = '0;
    for (int i = MAX_STEPS - 1; i >= 0; i--) begin
      if (usable[i]) begin
        entryFound = 1'b1;
        nextIdx = STEP_W'(i);
      end
    end
  end

  chan_e curChan;
  assign curChan = entryChan(modeQ, int'(step));
  assign chanSel = curChan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      enQ <= '0;
      step <= '0;
      resValid <= 1'b0;
      resId <= 1'b0;
      resData <= '0;
    end else begin
      resValid <= 1'b0;
      if (ctl.load) begin
        modeQ <= modeSel;
        enQ <= auxEn;
        step <= '0;
      end else if (ctl.jump) begin
        step <= nextIdx;
      end else if (ctl.capture) begin
        step <= step + 1'b1;
        resValid <= 1'b1;
        resId <= chanId(curChan);
        resData <= convData;
      end
    end
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);
  // R6
  id_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> resId == $past(chanId(curChan)));
endmodule

// File: rtl/scan_seq_control.sv
module scan_seq_control
  import scan_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startPulse,
  input  logic     convDone,
  input  logic     entryFound,
  output seq_ctl_t ctl,
  output logic     convReq,
  output logic     busy
);
  typedef enum logic [1:0] {S_IDLE, S_SEEK, S_REQ} state_e;
  state_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    ctl = '0;
    case (state)
      S_IDLE: if (startPulse) begin
        ctl.load = 1'b1;
        stateNxt = S_SEEK;
      end
      S_SEEK: if (entryFound) begin
        ctl.jump = 1'b1;
        stateNxt = S_REQ;
      end else begin
        stateNxt = S_IDLE;
      end
      S_REQ: if (convDone) begin
        ctl.capture = 1'b1;
        stateNxt = S_SEEK;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else state <= stateNxt;
  end

  assign convReq = (state == S_REQ);
  assign busy = (state != S_IDLE);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctl.load);
  // R10
  seek_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SEEK && !entryFound) |=> !busy);
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_seq_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modeSel,
  input  logic [2:0]        auxEn,
  input  logic              startPulse,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  output logic [2:0]        chanSel,
  output logic              convReq,
  output logic              busy,
  output logic              resValid,
  output logic              resId,
  output logic [DATA_W-1:0] resData
);
  seq_ctl_t ctl;
  logic entryFound;

  scan_seq_control u_ctl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .convDone(convDone),
    .entryFound(entryFound), .ctl(ctl), .convReq(convReq), .busy(busy)
  );

  scan_seq_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .modeSel(modeSel), .auxEn(auxEn),
    .convData(convData), .entryFound(entryFound), .chanSel(chanSel),
    .resValid(resValid), .resId(resId), .resData(resData)
  );

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && !convDone) |=> (convReq && $stable(chanSel)));
  // R7
  result_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && convDone) |=> (resValid && resData == $past(convData)));
  // R9
  stray_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!convReq && convDone) |=> !resValid);
endmodule

// File: tb/scan_sequencer_test.sv
`timescale 1ns/1ps
module scan_sequencer_test;
  localparam int DW = 12;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] modeSel = '0;
  logic [2:0] auxEn = '0;
  logic startPulse = 1'b0;
  logic convDone = 1'b0;
  logic [DW-1:0] convData = '0;
  logic [2:0] chanSel;
  logic convReq, busy, resValid, resId;
  logic [DW-1:0] resData;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  scan_sequencer #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .auxEn(auxEn),
    .startPulse(startPulse), .convDone(convDone), .convData(convData),
    .chanSel(chanSel), .convReq(convReq), .busy(busy), .resValid(resValid),
    .resId(resId), .resData(resData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected channel list per requirement R1..R5
  function automatic int expList(input logic [2:0] m, input logic [2:0] en, output int lst[4]);
    int n = 0;
    lst = '{0, 0, 0, 0};
    case (m)
      3'd0: begin lst[0] = 1; lst[1] = 0; n = 2; end
      3'd1: begin lst[0] = 1; lst[1] = 0; lst[2] = 2; lst[3] = 3; n = 4; end
      3'd2: begin lst[0] = 2; lst[1] = 3; n = 2; end
      3'd3: begin
        if (en[0]) begin lst[n] = 5; n++; end
        if (en[1]) begin lst[n] = 6; n++; end
        if (en[2]) begin lst[n] = 7; n++; end
      end
      default: begin lst[0] = 4; lst[1] = 5; lst[2] = 6; n = 3; end
    endcase
    return n;
  endfunction

  function automatic logic expId(input int ch);  // R6
    return (ch == 1) || (ch == 3) || (ch == 5) || (ch == 7);
  endfunction

  function automatic string modeReq(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic runScan(input logic [2:0] m, input logic [2:0] en,
                         input bit extraStart, input bit strayDone);
    int lst[4];
    int n;
    int idx = 0;
    int guard = 0;
    logic [DW-1:0] d;
    n = expList(m, en, lst);
    @(negedge clk);
    modeSel = m; auxEn = en; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    modeSel = 3'($urandom % 5); auxEn = 3'($urandom);   // R8: must not matter
    while (busy && guard < 200) begin
      guard++;
      if (convReq) begin
        check(modeReq(m), {31'd0, idx < n}, 32'd1);
        if (idx < n) check(modeReq(m), 32'(chanSel), 32'(lst[idx]));
        repeat ($urandom % 3) begin
          if (extraStart) startPulse = 1'b1;   // R8
          @(negedge clk);
          startPulse = 1'b0;
          check("R12", {31'd0, convReq}, 32'd1);
          if (idx < n) check("R12", 32'(chanSel), 32'(lst[idx]));
        end
        d = DW'($urandom);
        convDone = 1'b1; convData = d;
        @(negedge clk);
        convDone = 1'b0;
        check("R7", {31'd0, resValid}, 32'd1);
        check("R7", 32'(resData), 32'(d));
        if (idx < n) check("R6", {31'd0, resId}, {31'd0, expId(lst[idx])});
        idx++;
        if (strayDone) begin
          convDone = 1'b1;   // R9: no request open here
          @(negedge clk);
          convDone = 1'b0;
          check("R9", {31'd0, resValid}, 32'd0);
        end
      end else begin
        @(negedge clk);
        if (resValid) check("R9", 32'd1, 32'd0);
      end
    end
    check("R12", {31'd0, busy}, 32'd0);
    check(m == 3'd3 && en == 3'd0 ? "R10" : "R8", 32'(idx), 32'(n));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11
    check("R11", {29'd0, busy, convReq, resValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", {29'd0, busy, convReq, resValid}, 32'd0);
    // directed
    runScan(3'd0, 3'd0, 1'b0, 1'b0);
    runScan(3'd1, 3'd0, 1'b1, 1'b1);
    runScan(3'd2, 3'd0, 1'b0, 1'b1);
    runScan(3'd4, 3'd0, 1'b1, 1'b0);
    for (int e = 0; e < 8; e++) runScan(3'd3, 3'(e), 1'b1, 1'b1);
    runScan(3'd3, 3'd0, 1'b0, 1'b0);   // R10
    check("R10", {31'd0, convReq}, 32'd0);
    // random
    for (int k = 0; k < 60; k++)
      runScan(3'($urandom % 5), 3'($urandom), 1'($urandom), 1'($urandom));
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule